// File: doc/BRIEF.md
# ChaCha20 Block XOR Engine

This engine encrypts or decrypts one 64-byte block with the ChaCha20 stream cipher. The caller presents a complete 16-word cipher state (constants, key, counter and nonce already arranged) together with 64 bytes of data, and pulses `start`. The engine then runs the 20-round permutation on a single row-parallel datapath, one half-round per clock. It adds the original state back in, XORs the keystream with the data and presents the result on `dataOut` with a one-cycle `done` pulse.

The state is held as four rows of four 32-bit words. In each half-round, the four quarter-rounds work on the columns at the same time. To reach the diagonals, rows 1, 2 and 3 are rotated by word positions after the column pass, and they are rotated back after the diagonal pass, so the quarter-round hardware never changes its wiring. The engine applies the same keystream whether it encrypts or decrypts, so sending the result back through with the same state returns the plaintext.

Top module: `chacha_xor_engine`

## Requirements
- R1: While `rstN` is low at a clock edge, `busy` and `done` go low and `dataOut` is cleared to zero.
- R2: A `start` sampled high while `busy` is low captures `stateIn` and `dataIn`, and `busy` is high in the following cycle.
- R3: `done` is high for exactly one cycle, 21 clock edges after the edge that accepted `start` (20 half-round edges plus one finishing edge), and `busy` is low from that cycle on.
- R4: A `start` pulse, or a change of `stateIn` or `dataIn`, while `busy` is high has no effect: the running block finishes with its original inputs and latency, and no second block follows.
- R5: State word k sits at `stateIn[32k+31:32k]`, and row r holds words 4r to 4r+3. The engine runs 10 double rounds, each a column half-round followed by a diagonal half-round. The quarter-round steps are add, XOR and rotate-left by 16, 12, 8 and 7. All sums wrap modulo 2^32.
- R6: Output word k equals (permuted word k + input state word k, modulo 2^32) XOR `dataIn[32k+31:32k]`. Keystream bytes are serialised least significant byte first, so byte j of the block is bits 8j+7:8j.
- R7: With all-zero data the output equals the raw keystream, and states that drive every word to all-ones exercise wrap-around in the additions.
- R8: Feeding an output block back in with the same state returns the original data.
- R9: `dataOut` keeps its value from one `done` until the next `done`, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to process the presented state and data |
| stateIn | input | 512 | Cipher state, word k in bits 32k+31:32k |
| dataIn | input | 512 | Data block, byte j in bits 8j+7:8j |
| busy | output | 1 | High while a block is being processed |
| done | output | 1 | One-cycle pulse when `dataOut` holds a new result |
| dataOut | output | 512 | Data XOR keystream, same byte layout as `dataIn` |

## Verification
The assertions check the handshake on every cycle. They confirm that `done` is a single-cycle pulse, that `busy` drops when it fires, that `busy` only rises after an accepted `start`, that the start-to-done latency is 21 edges even when `start` is pulsed mid-run, and that `dataOut` changes only alongside `done`. They cannot tell whether the output value is right. The directed scenarios show that: they compare each block against an independent reference that indexes the diagonals directly, use all-zero data to expose the keystream and all-ones states to force wrap-around, and run a round trip that returns the plaintext.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
  typedef logic [31:0] word_t;
  typedef logic [3:0][31:0] row_t;
  typedef logic [3:0][3:0][31:0] state_t;

  typedef struct packed {
    logic load;
    logic step;
    logic diag;
    logic finish;
  } ctrl_t;

  function automatic word_t rotl32(word_t x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // word i of the result is word (i + n) mod 4 of the input
  function automatic row_t rotRow(row_t r, int n);
    row_t o;
    for (int i = 0; i < 4; i++) o[i] = r[(i + n) % 4];
    return o;
  endfunction
endpackage

// File: rtl/chacha_qr.sv
module chacha_qr
  import chacha_pkg::*;
(
  input  word_t aIn,
  input  word_t bIn,
  input  word_t cIn,
  input  word_t dIn,
  output word_t aOut,
  output word_t bOut,
  output word_t cOut,
  output word_t dOut
);
  word_t a1, d1, c1, b1, a2, d2, c2;

  always_comb begin
    a1 = aIn + bIn;
    d1 = rotl32(dIn ^ a1, 16);
    c1 = cIn + d1;
    b1 = rotl32(bIn ^ c1, 12);
    a2 = a1 + b1;
    d2 = rotl32(d1 ^ a2, 8);
    c2 = c1 + d2;
    aOut = a2;
    dOut = d2;
    cOut = c2;
    bOut = rotl32(b1 ^ c2, 7);
  end
endmodule

// File: rtl/chacha_datapath.sv
module chacha_datapath
  import chacha_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_t        ctl,
  input  logic [511:0] stateIn,
  input  logic [511:0] dataIn,
  output logic [511:0] dataOut
);
  state_t work, orig, qrOut, nextWork;
  logic [511:0] dataReg, resultFlat;

  // four quarter-rounds, one per column
  for (genvar col = 0; col < 4; col++) begin : g_col
    chacha_qr qr_i (
      .aIn (work[0][col]),
      .bIn (work[1][col]),
      .cIn (work[2][col]),
      .dIn (work[3][col]),
      .aOut(qrOut[0][col]),
      .bOut(qrOut[1][col]),
      .cOut(qrOut[2][col]),
      .dOut(qrOut[3][col])
    );
  end

  // column pass skews rows onto the diagonals; diagonal pass undoes it
  always_comb begin
    nextWork[0] = qrOut[0];
    if (ctl.diag) begin
      nextWork[1] = rotRow(qrOut[1], 3);
      nextWork[2] = rotRow(qrOut[2], 2);
      nextWork[3] = rotRow(qrOut[3], 1);
    end else begin
      nextWork[1] = rotRow(qrOut[1], 1);
      nextWork[2] = rotRow(qrOut[2], 2);
      nextWork[3] = rotRow(qrOut[3], 3);
    end
  end

  for (genvar k = 0; k < 16; k++) begin : g_out
    assign resultFlat[32*k +: 32] =
      (work[k/4][k%4] + orig[k/4][k%4]) ^ dataReg[32*k +: 32];
  end

  always_ff @(posedge clk) begin
    if (ctl.load) begin
      work    <= state_t'(stateIn);
      orig    <= state_t'(stateIn);
      dataReg <= dataIn;
    end else if (ctl.step) begin
      work <= nextWork;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           dataOut <= '0;
    else if (ctl.finish) dataOut <= resultFlat;
  end
endmodule

// File: rtl/chacha_ctrl.sv
module chacha_ctrl
  import chacha_pkg::*;
#(
  parameter int DOUBLE_ROUNDS = 10
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  output ctrl_t ctl,
  output logic  busy,
  output logic  done
);
  localparam int HALF_ROUNDS = 2 * DOUBLE_ROUNDS;
  localparam int CNT_W = $clog2(HALF_ROUNDS + 1);

  logic [CNT_W-1:0] stepCnt;
  logic lastStep;

  assign lastStep = (stepCnt == CNT_W'(HALF_ROUNDS));

  always_comb begin
    ctl.load   = start && !busy;
    ctl.step   = busy && !lastStep;
    ctl.diag   = stepCnt[0];
    ctl.finish = busy && lastStep;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
    end else begin
      done <= ctl.finish;
      if (ctl.load) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (ctl.finish) begin
        busy <= 1'b0;
      end else if (ctl.step) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/chacha_xor_engine.sv
module chacha_xor_engine
  import chacha_pkg::*;
#(
  parameter int DOUBLE_ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [511:0] stateIn,
  input  logic [511:0] dataIn,
  output logic         busy,
  output logic         done,
  output logic [511:0] dataOut
);
  ctrl_t ctl;

  chacha_ctrl #(.DOUBLE_ROUNDS(DOUBLE_ROUNDS)) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctl  (ctl),
    .busy (busy),
    .done (done)
  );

  chacha_datapath dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .stateIn(stateIn),
    .dataIn (dataIn),
    .dataOut(dataOut)
  );
endmodule

// File: rtl/chacha_xor_engine_chk.sv
module chacha_xor_engine_chk #(
  parameter int DOUBLE_ROUNDS = 10
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [511:0] dataOut
);
  localparam int LATENCY = 2 * DOUBLE_ROUNDS + 1;

  logic [7:0] latCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                latCnt <= '0;
    else if (start && !busy)  latCnt <= '0;
    else if (busy)            latCnt <= latCnt + 1'b1;
  end

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r3_busy_drops: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  a_r3_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (latCnt == 8'(LATENCY)));

  a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));

  a_r9_output_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> done);
endmodule

bind chacha_xor_engine chacha_xor_engine_chk #(.DOUBLE_ROUNDS(DOUBLE_ROUNDS)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .dataOut(dataOut)
);

// File: tb/chacha_xor_engine_tb_top.sv
module chacha_xor_engine_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [511:0] stateIn = '0;
  logic [511:0] dataIn = '0;
  logic         busy, done;
  logic [511:0] dataOut;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  chacha_xor_engine dut_i (
    .clk(clk), .rstN(rstN), .start(start), .stateIn(stateIn),
    .dataIn(dataIn), .busy(busy), .done(done), .dataOut(dataOut)
  );

  function automatic logic [31:0] rl(logic [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // reference: diagonals indexed directly, no row rotation
  function automatic logic [511:0] refBlock(logic [511:0] s, logic [511:0] d);
    logic [31:0] x[16];
    logic [511:0] o;
    int ia, ib, ic, id;
    for (int k = 0; k < 16; k++) x[k] = s[32*k +: 32];
    for (int dr = 0; dr < 10; dr++) begin
      for (int q = 0; q < 8; q++) begin
        if (q < 4) begin
          ia = q; ib = q + 4; ic = q + 8; id = q + 12;
        end else begin
          ia = q - 4; ib = 4 + (q - 3) % 4; ic = 8 + (q - 2) % 4; id = 12 + (q - 1) % 4;
        end
        x[ia] = x[ia] + x[ib]; x[id] = rl(x[id] ^ x[ia], 16);
        x[ic] = x[ic] + x[id]; x[ib] = rl(x[ib] ^ x[ic], 12);
        x[ia] = x[ia] + x[ib]; x[id] = rl(x[id] ^ x[ia], 8);
        x[ic] = x[ic] + x[id]; x[ib] = rl(x[ib] ^ x[ic], 7);
      end
    end
    for (int k = 0; k < 16; k++)
      o[32*k +: 32] = (x[k] + s[32*k +: 32]) ^ d[32*k +: 32];
    return o;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [511:0] act,
                       input logic [511:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drives one block; returns output and edge count from start to done
  task automatic runBlock(input logic [511:0] s, input logic [511:0] d,
                          output logic [511:0] res, output int lat);
    @(negedge clk);
    stateIn = s; dataIn = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", 512'(busy), 512'd1);
    lat = 0;
    while (done !== 1'b1 && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    res = dataOut;
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R3 done single pulse",
          512'({busy, done}), 512'd0);
  endtask

  function automatic logic [511:0] mkState(logic [31:0] seed);
    logic [511:0] s;
    for (int k = 0; k < 16; k++) s[32*k +: 32] = seed * (k + 1) ^ 32'h9e3779b9 * k;
    return s;
  endfunction

  task automatic t_reset();
    check(busy === 1'b0 && done === 1'b0, "R1 flags in reset", 512'({busy, done}), 512'd0);
    check(dataOut === '0, "R1 output cleared", dataOut, '0);
  endtask

  task automatic t_vectors();
    logic [511:0] s, d, r;
    int lat;
    for (int v = 0; v < 3; v++) begin
      s = mkState(32'h01234567 + 32'(v) * 32'h1111);
      s[127:0] = {32'h6b206574, 32'h79622d32, 32'h3320646e, 32'h61707865};
      d = mkState(32'hcafef00d ^ 32'(v));
      runBlock(s, d, r, lat);
      check(lat == 21, "R3 latency", 512'(lat), 512'd21);
      check(r === refBlock(s, d), "R5 R6 block vs reference", r, refBlock(s, d));
    end
  endtask

  task automatic t_keystream_wrap();
    logic [511:0] s, r;
    int lat;
    s = mkState(32'h5a5a1234);
    runBlock(s, '0, r, lat);
    check(r === refBlock(s, '0), "R7 zero data gives keystream", r, refBlock(s, '0));
    s = '1;
    runBlock(s, '0, r, lat);
    check(r === refBlock(s, '0), "R7 all-ones state wrap", r, refBlock(s, '0));
    runBlock(s, '1, r, lat);
    check(r === refBlock(s, '1), "R7 all-ones state and data", r, refBlock(s, '1));
  endtask

  task automatic t_ignore_start();
    logic [511:0] s, d, r;
    int lat;
    s = mkState(32'h0badbeef);
    d = mkState(32'h00c0ffee);
    @(negedge clk);
    stateIn = s; dataIn = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    stateIn = '1; dataIn = mkState(32'h77); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 6;
    while (done !== 1'b1 && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    r = dataOut;
    check(lat == 21, "R4 latency unchanged by mid-run start", 512'(lat), 512'd21);
    check(r === refBlock(s, d), "R4 result uses original inputs", r, refBlock(s, d));
    lat = 0;
    repeat (30) begin
      @(negedge clk);
      if (done === 1'b1 || busy === 1'b1) lat++;
    end
    check(lat == 0, "R4 no second block", 512'(lat), 512'd0);
  endtask

  task automatic t_roundtrip();
    logic [511:0] s, d, c, p;
    int lat;
    s = mkState(32'h13579bdf);
    d = mkState(32'h2468ace0);
    runBlock(s, d, c, lat);
    check(c !== d, "R8 ciphertext differs", c, d);
    runBlock(s, c, p, lat);
    check(p === d, "R8 round trip recovers data", p, d);
  endtask

  task automatic t_hold();
    logic [511:0] s, r;
    int lat;
    s = mkState(32'hfeedface);
    runBlock(s, mkState(32'h42), r, lat);
    stateIn = '0; dataIn = '1;
    repeat (10) @(negedge clk);
    check(dataOut === r, "R9 output held", dataOut, r);
    check(done === 1'b0, "R9 no done without start", 512'(done), 512'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_vectors();
    t_keystream_wrap();
    t_ignore_start();
    t_roundtrip();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule